// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block watches over loads that a compiler has moved above earlier stores. When such a load issues early, it records its byte range and the tag of the register it wrote. Every later store is compared against all recorded ranges at once. A store whose bytes touch a recorded range marks that record as spoiled. A check request, placed where the load originally sat in program order, then asks about one register tag. One cycle later the block answers with one of two results: the loaded value may be kept, or the load must be executed again.

The table holds a fixed number of records. A new early load whose tag is already present replaces that record. Otherwise it takes the lowest free record, or, when every record is in use, evicts one in rotating order. A check that finds no record for its tag asks for re-execution, because the block can no longer vouch for the value. Every check that finds a record releases it, whatever the answer.

Top module: `hoist_guard`

## Requirements
- R1: While reset is low, and in the cycle after its release, `resp_valid` is 0 and the table holds no records, so a first check asks for re-execution.
- R2: `resp_valid` is 1 in exactly the cycle after a cycle with `chk_valid` = 1, and 0 otherwise.
- R3: A check on a tag whose record saw no overlapping store gives `resp_replay` = 0 (keep the value).
- R4: Access size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, starting at the given byte address. A store whose byte range shares at least one byte with a record's range, including a partial overlap, makes a later check of that record give `resp_replay` = 1.
- R5: A store whose range only borders a record's range (no shared byte) leaves the record unspoiled.
- R6: A check on a tag with no record gives `resp_replay` = 1.
- R7: A check that finds a record releases it, so a second check on the same tag gives `resp_replay` = 1.
- R8: An early load whose tag matches a record replaces that record's range and clears its spoiled mark; at most one record holds any tag.
- R9: With every record in use, an early load with a new tag evicts records in rotating order, the first eviction taking the record filled first after reset; a full table stays full.
- R10: A store arriving in the same cycle as an early load is compared only with the records already present, never with the one being written.
- R11: A store arriving in the same cycle as a check counts against the checked record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | An early load issues this cycle |
| ld_addr | input | ADDR_W | Byte address of the early load |
| ld_size | input | 2 | Size code of the early load |
| ld_tag | input | TAG_W | Destination register tag of the early load |
| st_valid | input | 1 | A store issues this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | A check request this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| resp_valid | output | 1 | Answer to the check of the previous cycle is present |
| resp_replay | output | 1 | 1 = execute the load again, 0 = keep the loaded value |

## Verification
The bench uses the default parameters: eight records, 32-bit addresses and 7-bit tags. Eight records let a short sequence fill the table and push two rotating evictions, so the order of victims can be seen from which checks ask for re-execution. The 32-bit address space leaves room for ranges placed on either side of a record, exactly bordering it or sharing one byte, for every size code.

// File: rtl/hoist_guard_pkg.sv
// Shared definitions for the hoisted-load conflict table.
// Assumes byte addressing and power-of-two access sizes up to 8 bytes.
package hoist_guard_pkg;

    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        ACC_1B = 2'd0,
        ACC_2B = 2'd1,
        ACC_4B = 2'd2,
        ACC_8B = 2'd3
    } acc_size_e;

    // Byte count of an access from its size code.
    function automatic logic [3:0] size_bytes(input logic [SIZE_W-1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/hoist_guard_overlap.sv
// Byte-range overlap comparator.
// Says whether two accesses share at least one byte. The sums are taken one
// bit wider than the address so a range ending at the top of memory does
// not wrap around.
module hoist_guard_overlap
    import hoist_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [SIZE_W-1:0] b_size,
    output logic              hit
);

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_end, b_lo, b_end;

    // Half-open ranges [lo, end) compared for intersection.
    always_comb begin
        a_lo  = {1'b0, a_addr};
        b_lo  = {1'b0, b_addr};
        a_end = a_lo + EXT_W'(size_bytes(a_size));
        b_end = b_lo + EXT_W'(size_bytes(b_size));
        hit   = (a_lo < b_end) && (b_lo < a_end);
    end

endmodule

// File: rtl/hoist_guard_entry.sv
// One record of the conflict table.
// Holds the range and tag of one early load plus its spoiled mark. Writing a
// new load takes priority over release and over store marking in the same
// cycle; a store therefore never marks a record that is being written.
module hoist_guard_entry
    import hoist_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              free_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              valid,
    output logic              spoiled,
    output logic              ld_tag_hit,
    output logic              chk_tag_hit,
    output logic              st_hit
);

    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [TAG_W-1:0]  tag_q;
    logic              range_hit;

    hoist_guard_overlap #(.ADDR_W(ADDR_W)) u_cmp (
        .a_addr (addr_q),
        .a_size (size_q),
        .b_addr (st_addr),
        .b_size (st_size),
        .hit    (range_hit)
    );

    // Tag and store matches against the current contents.
    always_comb begin
        ld_tag_hit  = valid && (tag_q == wr_tag);
        chk_tag_hit = valid && (tag_q == chk_tag);
        st_hit      = valid && st_valid && range_hit;
    end

    // Record contents: written by a load, released by a check, marked by a store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            spoiled <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            tag_q   <= '0;
        end else if (wr_en) begin
            valid   <= 1'b1;
            spoiled <= 1'b0;
            addr_q  <= wr_addr;
            size_q  <= wr_size;
            tag_q   <= wr_tag;
        end else if (free_en) begin
            valid   <= 1'b0;
            spoiled <= 1'b0;
        end else if (st_hit) begin
            spoiled <= 1'b1;
        end
    end

endmodule

// File: rtl/hoist_guard_victim.sv
// Record selection for an incoming early load.
// Picks the record already holding the tag, else the lowest free record,
// else the record under a rotating pointer. The pointer moves only when an
// eviction actually happens. Uses the table state from before this cycle.
module hoist_guard_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] tag_hit_vec,
    output logic [IDX_W-1:0]   slot
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] tag_idx, free_idx;
    logic             any_tag, any_free;

    // Priority search over tag matches and free records (lowest index wins).
    always_comb begin
        tag_idx  = '0;
        free_idx = '0;
        any_tag  = |tag_hit_vec;
        any_free = ~&valid_vec;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tag_hit_vec[i]) tag_idx = IDX_W'(i);
            if (!valid_vec[i])  free_idx = IDX_W'(i);
        end
        if (any_tag)       slot = tag_idx;
        else if (any_free) slot = free_idx;
        else               slot = rr_ptr;
    end

    // Rotating eviction pointer, advanced on each eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (ld_valid && !any_tag && !any_free) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/hoist_guard.sv
// Hoisted-load conflict table, top level.
// Early loads record their byte range under a register tag, stores spoil
// every overlapping record, and a check answers one cycle later whether the
// load must be executed again. Assumes at most one load, one store and one
// check per cycle. Within a cycle: the store and the check see the contents
// before the load is written; a store in the same cycle as a check counts.
module hoist_guard
    import hoist_guard_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              resp_valid,
    output logic              resp_replay
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_vec, spoiled_vec, ld_hit_vec, chk_hit_vec, st_hit_vec;
    logic [ENTRIES-1:0] wr_vec, free_vec;
    logic [IDX_W-1:0]   slot;
    logic               lookup_found, lookup_bad;

    hoist_guard_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .valid_vec   (valid_vec),
        .tag_hit_vec (ld_hit_vec),
        .slot        (slot)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rec
        // Write and release strobes for this record.
        assign wr_vec[g]   = ld_valid && (slot == IDX_W'(g));
        assign free_vec[g] = chk_valid && chk_hit_vec[g];

        hoist_guard_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_rec (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_vec[g]),
            .wr_addr     (ld_addr),
            .wr_size     (ld_size),
            .wr_tag      (ld_tag),
            .free_en     (free_vec[g]),
            .st_valid    (st_valid),
            .st_addr     (st_addr),
            .st_size     (st_size),
            .chk_tag     (chk_tag),
            .valid       (valid_vec[g]),
            .spoiled     (spoiled_vec[g]),
            .ld_tag_hit  (ld_hit_vec[g]),
            .chk_tag_hit (chk_hit_vec[g]),
            .st_hit      (st_hit_vec[g])
        );
    end

    // Lookup result: record present, and whether it is or is now being spoiled.
    always_comb begin
        lookup_found = |chk_hit_vec;
        lookup_bad   = |(chk_hit_vec & (spoiled_vec | st_hit_vec));
    end

    // Registered check answer, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_replay <= 1'b0;
        end else begin
            resp_valid  <= chk_valid;
            resp_replay <= chk_valid && (!lookup_found || lookup_bad);
        end
    end

endmodule

// File: rtl/hoist_guard_chk.sv
// Property checker for the hoisted-load conflict table, bound to the top.
// Observes the ports and the per-record valid and tag-match vectors.
module hoist_guard_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_valid,
    input logic               chk_valid,
    input logic               resp_valid,
    input logic               resp_replay,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] ld_hit_vec,
    input logic [ENTRIES-1:0] chk_hit_vec
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !resp_valid);

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> resp_valid);

    // R2
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !resp_valid);

    // R3
    keep_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_replay) |-> $past(chk_valid));

    // R6
    empty_table_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (valid_vec == '0)) |=> resp_replay);

    // R8
    unique_chk_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_hit_vec));

    // R8
    unique_ld_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_hit_vec));

    // R9
    full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !chk_valid && (&valid_vec)) |=> (&valid_vec));

endmodule

bind hoist_guard hoist_guard_chk #(.ENTRIES(ENTRIES)) u_hoist_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .chk_valid   (chk_valid),
    .resp_valid  (resp_valid),
    .resp_replay (resp_replay),
    .valid_vec   (valid_vec),
    .ld_hit_vec  (ld_hit_vec),
    .chk_hit_vec (chk_hit_vec)
);

// File: tb/test_hoist_guard.sv
// Directed bench for the hoisted-load conflict table.
module test_hoist_guard;

    localparam int ENTRIES = 8;
    localparam int ADDR_W  = 32;
    localparam int TAG_W   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic              chk_valid = 1'b0;
    logic [TAG_W-1:0]  chk_tag = '0;
    logic              resp_valid;
    logic              resp_replay;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    hoist_guard #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_hoist_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_size     (ld_size),
        .ld_tag      (ld_tag),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_size     (st_size),
        .chk_valid   (chk_valid),
        .chk_tag     (chk_tag),
        .resp_valid  (resp_valid),
        .resp_replay (resp_replay)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and drop all request strobes.
    task automatic tick();
        @(negedge clk);
        ld_valid  = 1'b0;
        st_valid  = 1'b0;
        chk_valid = 1'b0;
    endtask

    task automatic put_ld(input logic [ADDR_W-1:0] a, input logic [1:0] s, input logic [TAG_W-1:0] t);
        ld_valid = 1'b1; ld_addr = a; ld_size = s; ld_tag = t;
    endtask

    task automatic put_st(input logic [ADDR_W-1:0] a, input logic [1:0] s);
        st_valid = 1'b1; st_addr = a; st_size = s;
    endtask

    task automatic put_chk(input logic [TAG_W-1:0] t);
        chk_valid = 1'b1; chk_tag = t;
    endtask

    // Sample the answer after a tick that carried a check.
    task automatic expect_resp(input string req, input logic exp_replay);
        check_bit({req, " resp_valid"}, resp_valid, 1'b1);
        check_bit({req, " resp_replay"}, resp_replay, exp_replay);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tick();
    endtask

    // R1, R2, R6: reset state and empty-table lookup.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 resp_valid in reset", resp_valid, 1'b0);
        rst_n = 1'b1;
        tick();
        check_bit("R1 resp_valid after release", resp_valid, 1'b0);
        put_chk(7'd3); tick();
        expect_resp("R1 R6 check on empty table", 1'b1);
        tick();
        check_bit("R2 resp_valid drops after one cycle", resp_valid, 1'b0);
    endtask

    // R3, R7: clean check keeps, then the record is gone.
    task automatic t_clean_and_free();
        do_reset();
        put_ld(32'h0000_0800, 2'd2, 7'd8); tick();
        put_st(32'h0000_0900, 2'd3); tick();
        put_chk(7'd8); tick();
        expect_resp("R3 no conflicting store", 1'b0);
        put_chk(7'd8); tick();
        expect_resp("R7 second check after release", 1'b1);
    endtask

    // R4: partial and contained overlaps for several sizes.
    task automatic t_overlap();
        do_reset();
        put_ld(32'h0000_1004, 2'd2, 7'd1); tick();
        put_ld(32'h0000_2000, 2'd3, 7'd2); tick();
        put_ld(32'h0000_2800, 2'd0, 7'd9); tick();
        put_st(32'h0000_1006, 2'd2); tick();
        put_st(32'h0000_2007, 2'd0); tick();
        put_st(32'h0000_27FE, 2'd2); tick();
        put_chk(7'd1); tick();
        expect_resp("R4 partial overlap 4B vs 4B", 1'b1);
        put_chk(7'd2); tick();
        expect_resp("R4 last byte of 8B range", 1'b1);
        put_chk(7'd9); tick();
        expect_resp("R4 1B record inside 4B store", 1'b1);
    endtask

    // R5: stores bordering a record on each side.
    task automatic t_adjacent();
        do_reset();
        put_ld(32'h0000_3000, 2'd2, 7'd4); tick();
        put_st(32'h0000_3004, 2'd2); tick();
        put_st(32'h0000_2FFF, 2'd0); tick();
        put_st(32'h0000_2FF8, 2'd3); tick();
        put_chk(7'd4); tick();
        expect_resp("R5 bordering stores only", 1'b0);
    endtask

    // R6: check on a tag that was never loaded while others are present.
    task automatic t_missing();
        do_reset();
        put_ld(32'h0000_0400, 2'd1, 7'd12); tick();
        put_chk(7'd13); tick();
        expect_resp("R6 unknown tag", 1'b1);
        put_chk(7'd12); tick();
        expect_resp("R6 present tag unaffected", 1'b0);
    endtask

    // R8: same-tag reload replaces range and clears spoiled mark.
    task automatic t_overwrite();
        do_reset();
        put_ld(32'h0000_6000, 2'd2, 7'd7); tick();
        put_st(32'h0000_6000, 2'd2); tick();
        put_ld(32'h0000_7000, 2'd2, 7'd7); tick();
        put_st(32'h0000_6000, 2'd3); tick();
        put_chk(7'd7); tick();
        expect_resp("R8 reload clears mark and old range", 1'b0);
    endtask

    // R9: full table evicts in rotating order.
    task automatic t_evict();
        do_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            put_ld(32'h0001_0000 + 32'(i) * 32'h100, 2'd2, TAG_W'(10 + i)); tick();
        end
        put_ld(32'h0002_0000, 2'd2, 7'd30); tick();
        put_ld(32'h0002_0100, 2'd2, 7'd31); tick();
        put_chk(7'd10); tick();
        expect_resp("R9 first-filled record evicted", 1'b1);
        put_chk(7'd11); tick();
        expect_resp("R9 second record evicted next", 1'b1);
        put_chk(7'd12); tick();
        expect_resp("R9 third record kept", 1'b0);
        put_chk(7'd30); tick();
        expect_resp("R9 new record present", 1'b0);
        put_chk(7'd31); tick();
        expect_resp("R9 second new record present", 1'b0);
    endtask

    // R10, R11: same-cycle ordering rules.
    task automatic t_same_cycle();
        do_reset();
        put_ld(32'h0000_4000, 2'd2, 7'd5);
        put_st(32'h0000_4000, 2'd2); tick();
        put_chk(7'd5); tick();
        expect_resp("R10 store with load not compared to it", 1'b0);
        put_ld(32'h0000_5000, 2'd2, 7'd6); tick();
        put_st(32'h0000_5002, 2'd0);
        put_chk(7'd6); tick();
        expect_resp("R11 store with check counts", 1'b1);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_clean_and_free();
        t_overlap();
        t_adjacent();
        t_missing();
        t_overwrite();
        t_evict();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule